// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides, for each received frame, whether its 48-bit destination address should be kept. Frame parsing logic presents the address together with a one-cycle strobe. One clock later the block returns an accept decision, a code naming the rule that produced it, and the 6-bit hash index it computed.

The block applies these rules. An exact match against the programmed station address is always kept. The all-ones broadcast address is kept unless broadcast rejection is configured. A 64-entry hash table is indexed by an XOR fold of the address, and it serves multicast or unicast addresses according to the address's group bit and two enable bits. A copy-everything mode keeps every frame. The station address and hash table arrive as register words, and the block holds no copy of them.

Address bit 0 is the least significant bit of the first byte on the wire, which is the group (multicast) indicator. Bit 47 is the most significant bit of the last byte. So `dst_addr[7:0]` is the first byte received.

Top module: `da_filter`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `res_valid` and `res_accept` are 0, `res_kind` is 0 and `res_index` is 0.
- R2: `res_valid` is high in exactly the cycle after a cycle with `addr_valid` high. `res_accept`, `res_kind` and `res_index` take the new result in that cycle and keep their values while `addr_valid` is low.
- R3: `res_index` bit n (n = 0..5) equals the XOR of `dst_addr` bits n, n+6, n+12, …, n+42.
- R4: Hash index k selects table bit k&31 of `hash_lo` when k < 32, and bit k&31 of `hash_hi` when k ≥ 32.
- R5: A non-broadcast address with bit 0 = 1 is accepted with kind 3 when `mhash_en` is 1 and the indexed table bit is 1.
- R6: An address with bit 0 = 0 is accepted with kind 4 when `uhash_en` is 1 and the indexed table bit is 1.
- R7: An address equal to {`sta_hi`, `sta_lo`} is always accepted with kind 1, whatever the other settings are. `sta_lo[7:0]` is the first byte received.
- R8: The all-ones address is accepted with kind 2 when `no_bcast` is 0. When `no_bcast` is 1 it is rejected (kind 0) unless `copy_all` is 1, and the hash table is never consulted for it.
- R9: When `copy_all` is 1, every address is accepted. Kind 5 is reported when no other rule matches.
- R10: Kind codes are NONE=0, STATION=1, BROADCAST=2, MULTICAST-HASH=3, UNICAST-HASH=4, COPY-ALL=5. When several rules hold, the lowest nonzero code is reported. `res_accept` is 1 exactly when the kind is nonzero.
- R11: With both hash words all ones and `mhash_en` set, every non-broadcast multicast address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Strobe: `dst_addr` holds a new address |
| dst_addr | input | 48 | Destination address, bit 0 first on the wire |
| sta_lo | input | 32 | Station address bytes 0..3, byte 0 in bits 7:0 |
| sta_hi | input | 16 | Station address bytes 4..5 |
| hash_lo | input | 32 | Hash table bits 0..31 |
| hash_hi | input | 32 | Hash table bits 32..63 |
| uhash_en | input | 1 | Enable unicast hash matching |
| mhash_en | input | 1 | Enable multicast hash matching |
| copy_all | input | 1 | Accept every frame |
| no_bcast | input | 1 | Reject the broadcast address |
| res_valid | output | 1 | Result strobe, one cycle after `addr_valid` |
| res_accept | output | 1 | Frame accepted |
| res_kind | output | 3 | Rule that decided (see R10) |
| res_index | output | 6 | Computed hash index |

## Verification
The block has one pipeline stage and holds no state beyond its result registers. Any internal fault therefore appears on the ports in the very next result. A fold that misses a tap shows as a wrong `res_index` for about half of all random addresses. Swapping the table words, or testing the group bit the wrong way, flips `res_accept` whenever the two table halves or the two enables differ. A priority fault shows as a wrong `res_kind` on an address that also hits a lower rule. Random addresses biased towards the station address and broadcast, with random table contents and enables, reach each of these within a few dozen strobes.

// File: rtl/da_filter_pkg.sv
package da_filter_pkg;
  typedef enum logic [2:0] {
    KIND_NONE    = 3'd0,
    KIND_STATION = 3'd1,
    KIND_BCAST   = 3'd2,
    KIND_MHASH   = 3'd3,
    KIND_UHASH   = 3'd4,
    KIND_COPY    = 3'd5
  } match_kind_e;
endpackage

// File: rtl/da_hash_fold.sv
module da_hash_fold #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int TAPS = (ADDR_W + IDX_W - 1) / IDX_W;

  // Each index bit folds every IDX_W-th address bit together.
  for (genvar n = 0; n < IDX_W; n++) begin : g_fold
    always_comb begin
      idx[n] = 1'b0;
      for (int k = 0; k < TAPS; k++) begin
        if (n + k * IDX_W < ADDR_W) idx[n] = idx[n] ^ addr[n + k * IDX_W];
      end
    end
  end
endmodule

// File: rtl/da_table_pick.sv
module da_table_pick #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic [WORD_W-1:0] word_lo,
  input  logic [WORD_W-1:0] word_hi,
  input  logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int SEL_W = $clog2(WORD_W);

  logic [WORD_W-1:0] word;
  assign word = idx[IDX_W-1] ? word_hi : word_lo;
  assign hit  = word[idx[SEL_W-1:0]];
endmodule

// File: rtl/da_decide.sv
module da_decide
  import da_filter_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] station,
  input  logic              tbl_hit,
  input  logic              uhash_en,
  input  logic              mhash_en,
  input  logic              copy_all,
  input  logic              no_bcast,
  output match_kind_e       kind,
  output logic              accept
);
  logic is_sta, is_bc, is_grp, hash_ok;

  assign is_sta  = (addr == station);
  assign is_bc   = &addr;
  assign is_grp  = addr[0];
  assign hash_ok = tbl_hit && (is_grp ? mhash_en : uhash_en);

  always_comb begin
    if (is_sta)                           kind = KIND_STATION;
    else if (is_bc && !no_bcast)          kind = KIND_BCAST;
    else if (is_bc)                       kind = copy_all ? KIND_COPY : KIND_NONE;
    else if (is_grp && mhash_en && tbl_hit)  kind = KIND_MHASH;
    else if (!is_grp && uhash_en && tbl_hit) kind = KIND_UHASH;
    else if (copy_all)                    kind = KIND_COPY;
    else                                  kind = KIND_NONE;
  end

  // Acceptance formed as a sum of rules, independent of the priority chain.
  assign accept = is_sta | copy_all | (is_bc & ~no_bcast) | (~is_bc & hash_ok);
endmodule

// File: rtl/da_filter.sv
module da_filter
  import da_filter_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 addr_valid,
  input  logic [ADDR_W-1:0]    dst_addr,
  input  logic [WORD_W-1:0]    sta_lo,
  input  logic [ADDR_W-WORD_W-1:0] sta_hi,
  input  logic [WORD_W-1:0]    hash_lo,
  input  logic [WORD_W-1:0]    hash_hi,
  input  logic                 uhash_en,
  input  logic                 mhash_en,
  input  logic                 copy_all,
  input  logic                 no_bcast,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic [2:0]           res_kind,
  output logic [IDX_W-1:0]     res_index
);
  logic [ADDR_W-1:0] station;
  logic [IDX_W-1:0]  idx;
  logic              tbl_hit;
  match_kind_e       kind;
  logic              accept;

  assign station = {sta_hi, sta_lo};

  da_hash_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fold (
    .addr (dst_addr),
    .idx  (idx)
  );

  da_table_pick #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_pick (
    .word_lo (hash_lo),
    .word_hi (hash_hi),
    .idx     (idx),
    .hit     (tbl_hit)
  );

  da_decide #(.ADDR_W(ADDR_W)) u_decide (
    .addr     (dst_addr),
    .station  (station),
    .tbl_hit  (tbl_hit),
    .uhash_en (uhash_en),
    .mhash_en (mhash_en),
    .copy_all (copy_all),
    .no_bcast (no_bcast),
    .kind     (kind),
    .accept   (accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_kind   <= KIND_NONE;
      res_index  <= '0;
    end else begin
      res_valid <= addr_valid;
      if (addr_valid) begin
        res_accept <= accept;
        res_kind   <= kind;
        res_index  <= idx;
      end
    end
  end

  // R2: result strobe follows the input strobe by one cycle
  p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> res_valid);
  // R2: outputs hold while no address is presented
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |=> ($stable(res_kind) && $stable(res_accept) && $stable(res_index)));
  // R10: accept agrees with a nonzero kind
  p_accept_kind_r10: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_accept == (res_kind != 3'd0)));
  // R9: copy-all never rejects
  p_copy_all_r9: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && copy_all) |=> res_accept);
  // R7: station match reported as kind 1
  p_station_r7: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && dst_addr == station) |=> (res_kind == 3'd1));
  // R8: broadcast rejected when configured and no override applies
  p_no_bcast_r8: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && &dst_addr && no_bcast && !copy_all && dst_addr != station)
      |=> !res_accept);
endmodule

// File: tb/da_filter_tb.sv
module da_filter_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        addr_valid;
  logic [47:0] dst_addr;
  logic [31:0] sta_lo;
  logic [15:0] sta_hi;
  logic [31:0] hash_lo, hash_hi;
  logic        uhash_en, mhash_en, copy_all, no_bcast;
  logic        res_valid, res_accept;
  logic [2:0]  res_kind;
  logic [5:0]  res_index;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  da_filter u_dut (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .dst_addr(dst_addr),
    .sta_lo(sta_lo), .sta_hi(sta_hi), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .uhash_en(uhash_en), .mhash_en(mhash_en), .copy_all(copy_all),
    .no_bcast(no_bcast), .res_valid(res_valid), .res_accept(res_accept),
    .res_kind(res_kind), .res_index(res_index)
  );

  function automatic logic [5:0] ref_index(logic [47:0] a);
    logic [5:0] r = '0;
    for (int i = 0; i < 48; i++) r[i % 6] = r[i % 6] ^ a[i];
    return r;
  endfunction

  function automatic logic [2:0] ref_kind(logic [47:0] a);
    logic [63:0] tbl = {hash_hi, hash_lo};
    logic        bit_set = tbl[ref_index(a)];
    if (a == {sta_hi, sta_lo}) return 3'd1;
    if (a == 48'hFFFF_FFFF_FFFF) begin
      if (!no_bcast) return 3'd2;
      return copy_all ? 3'd5 : 3'd0;
    end
    if (a[0] && mhash_en && bit_set) return 3'd3;
    if (!a[0] && uhash_en && bit_set) return 3'd4;
    if (copy_all) return 3'd5;
    return 3'd0;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one address, then sample the registered result mid-cycle.
  task automatic present(string req, logic [47:0] a);
    logic [2:0] ek;
    logic [5:0] ei;
    dst_addr   = a;
    addr_valid = 1'b1;
    ek = ref_kind(a);
    ei = ref_index(a);
    @(negedge clk);
    addr_valid = 1'b0;
    check({req, " R2 valid"}, 64'(res_valid), 64'd1);
    check({req, " R10 kind"}, 64'(res_kind), 64'(ek));
    check({req, " R10 accept"}, 64'(res_accept), 64'(ek != 3'd0));
    check({req, " R3 index"}, 64'(res_index), 64'(ei));
  endtask

  task automatic set_cfg(logic u, logic m, logic c, logic nb);
    uhash_en = u; mhash_en = m; copy_all = c; no_bcast = nb;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] held_kind;
    logic [5:0] held_idx;
    logic       held_acc;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; addr_valid = 1'b0; dst_addr = '0;
    sta_lo = 32'h33_22_11_00; sta_hi = 16'h55_44;
    hash_lo = '0; hash_hi = '0;
    set_cfg(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 valid", 64'(res_valid), 64'd0);
    check("R1 accept", 64'(res_accept), 64'd0);
    check("R1 kind", 64'(res_kind), 64'd0);
    check("R1 index", 64'(res_index), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 64'({res_valid, res_accept, res_kind, res_index}), 64'd0);

    // R3 fold taps
    present("R3 bit0", 48'h0000_0000_0001);
    check("R3 single tap", 64'(res_index), 64'd1);
    present("R3 bit6", 48'h0000_0000_0040);
    check("R3 tap6", 64'(res_index), 64'd1);
    present("R3 bits0+6", 48'h0000_0000_0041);
    check("R3 cancel", 64'(res_index), 64'd0);
    present("R3 bit47", 48'h8000_0000_0000);
    check("R3 tap47", 64'(res_index), 64'h20);

    // R4 word select: index 32 lives in hash_hi bit 0
    set_cfg(1, 0, 0, 0);
    hash_hi = 32'h1; hash_lo = 32'h0;
    present("R4 hi word", 48'h8000_0000_0000);
    check("R4 hi hit", 64'(res_kind), 64'd4);
    hash_hi = 32'h0; hash_lo = 32'h1;
    present("R4 lo word", 48'h8000_0000_0000);
    check("R4 lo miss", 64'(res_accept), 64'd0);

    // R5 / R6 group-bit selection
    hash_lo = 32'h2;
    set_cfg(1, 0, 0, 0);
    present("R5 mcast w/o enable", 48'h0000_0000_0001);
    check("R5 needs mhash_en", 64'(res_accept), 64'd0);
    set_cfg(0, 1, 0, 0);
    present("R5 mcast", 48'h0000_0000_0001);
    check("R5 mhash kind", 64'(res_kind), 64'd3);
    present("R6 ucast w/o enable", 48'h0000_0000_0040);
    check("R6 needs uhash_en", 64'(res_accept), 64'd0);
    set_cfg(1, 0, 0, 0);
    present("R6 ucast", 48'h0000_0000_0040);
    check("R6 uhash kind", 64'(res_kind), 64'd4);

    // R7 station beats everything, byte order
    set_cfg(1, 1, 1, 1);
    hash_lo = '1; hash_hi = '1;
    present("R7 station", 48'h5544_3322_1100);
    check("R7 kind", 64'(res_kind), 64'd1);
    set_cfg(0, 0, 0, 0);
    present("R7 byte swapped", 48'h0011_2233_4455);
    check("R7 no match", 64'(res_accept), 64'd0);

    // R8 broadcast
    present("R8 bcast", 48'hFFFF_FFFF_FFFF);
    check("R8 bcast kind", 64'(res_kind), 64'd2);
    set_cfg(1, 1, 0, 1);
    present("R8 bcast rejected", 48'hFFFF_FFFF_FFFF);
    check("R8 reject despite table", 64'(res_accept), 64'd0);
    set_cfg(0, 0, 1, 1);
    present("R8 R9 bcast copy", 48'hFFFF_FFFF_FFFF);
    check("R9 override", 64'(res_kind), 64'd5);

    // R9 copy_all on a plain address
    hash_lo = '0; hash_hi = '0;
    present("R9 copy", 48'h1234_5678_9ABC);
    check("R9 kind", 64'(res_kind), 64'd5);

    // R11 all-ones table
    hash_lo = '1; hash_hi = '1;
    set_cfg(0, 1, 0, 0);
    for (int i = 0; i < 40; i++) begin
      logic [47:0] a = {16'($urandom), $urandom};
      a[0] = 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) a[1] = 1'b0;
      present("R11 all multicast", a);
      check("R11 accept", 64'(res_accept), 64'd1);
    end

    // R2 hold while strobe low
    held_kind = res_kind; held_acc = res_accept; held_idx = res_index;
    dst_addr = 48'h0000_0000_0002;
    set_cfg(0, 0, 0, 1);
    @(negedge clk);
    @(negedge clk);
    check("R2 no strobe", 64'(res_valid), 64'd0);
    check("R2 hold", 64'({held_kind, held_acc, held_idx}),
          64'({res_kind, res_accept, res_index}));

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [47:0] a;
      int sel = $urandom_range(0, 9);
      sta_lo = $urandom; sta_hi = 16'($urandom);
      hash_lo = $urandom; hash_hi = $urandom;
      set_cfg(1'($urandom), 1'($urandom), ($urandom_range(0, 5) == 0), 1'($urandom));
      a = {16'($urandom), $urandom};
      if (sel == 0) a = {sta_hi, sta_lo};
      else if (sel == 1) a = 48'hFFFF_FFFF_FFFF;
      present("R5 R6 R7 R8 R9 random", a);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule